// File: doc/BRIEF.md
# Processor Interrupt Level Arbiter

The arbiter sits between the interrupt sources of a processor and its trap logic. Each cycle it merges two sources into one pending mask: sixteen external interrupt lines, one per level, and the value of the software interrupt register. From that mask it picks the highest level that may interrupt the processor now. The processor's current interrupt level, its global interrupt enable and the trap that is in progress all limit that choice. The result is a registered hard interrupt request together with an interrupt type code that the trap logic uses to vector.

The software interrupt register is taken as a 17-bit value. Bits 15:1 are software-raised levels. Bit 0 is the tick-compare match flag. Bit 16 is the system-tick-compare match flag. Neither match flag counts as a level of its own: both are removed from the mask and instead assert level 14. The block also gives a one-cycle wake pulse whenever an external line rises, which the core uses to leave its halted state.

Top module: `pil_arbiter`

## Requirements
- R1: External line `ext_irq[i]` pends level i. If that is the only pending level, i > `cur_pil` and `irq_en` is 1, the edge after the input is applied sets `irq_req` to 1 and `irq_type` to 0x40 | i.
- R2: Bits 15:1 of `soft_reg` pend the matching levels, just as the external lines do. Bit 0 and bit 16 never pend level 0 or a level of their own.
- R3: When `soft_reg` bit 0 (tick match) or bit 16 (system tick match) is 1, level 14 is pending, so the type is 0x4E when no higher level wins.
- R4: When no external line and no `soft_reg` bit is set, the next edge clears `irq_req` to 0 and `irq_type` to 0.
- R5: With `irq_en` at 1, only levels strictly above `cur_pil` are eligible, and the highest eligible pending level wins.
- R6: `irq_type` is nonzero only while `irq_req` is 1. It then lies in 0x41..0x4F, and its low four bits are the winning level. Its value reflects the inputs of the previous clock edge.
- R7: When `trap_lvl` is nonzero and `trap_type` is greater than the new type code, the outputs do not change. When `trap_type` is equal to or below the new code, or when `trap_lvl` is 0, the new code is taken.
- R8: While `irq_en` is 0 and something is pending, `irq_req` and `irq_type` hold their values.
- R9: When something is pending but no pending level is above `cur_pil` (level 0 is never eligible), the outputs hold.
- R10: `wake` is 1 for the cycle after an edge at which some external line was 1 and had been 0 at the previous edge. Otherwise it is 0.
- R11: During reset `irq_req`, `irq_type` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | 16 | External interrupt lines, bit i is level i |
| soft_reg | input | 17 | Software interrupt register: bit 0 tick match, bits 15:1 levels, bit 16 system tick match |
| cur_pil | input | 4 | Current processor interrupt level |
| irq_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| trap_type | input | 9 | Type of the trap in progress |
| irq_req | output | 1 | Hard interrupt request |
| irq_type | output | 9 | Selected interrupt type code |
| wake | output | 1 | One-cycle pulse after an external line rises |

## Verification
The bench builds the block with its default parameters: sixteen levels, a trap base of 0x40, a 9-bit type code and a 3-bit trap level. With these values the whole code range 0x41..0x4F can be reached, including the fold of both timer match bits onto level 14. The trap type is driven over 0x38..0x57, so it falls below, inside and above that range, and the blocking comparison meets both of its sides. A behavioural model runs on every clock beside directed cases for each corner.

// File: rtl/pil_arbiter.sv
module pil_arbiter #(
  parameter int LEVELS    = 16,
  parameter int TRAP_BASE = 'h40,
  parameter int TYPE_W    = 9,
  parameter int TL_W      = 3,
  localparam int PIL_W    = $clog2(LEVELS),
  localparam int SOFT_W   = LEVELS + 1,
  localparam int FOLD_LVL = LEVELS - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] ext_irq,
  input  logic [SOFT_W-1:0] soft_reg,
  input  logic [PIL_W-1:0]  cur_pil,
  input  logic              irq_en,
  input  logic [TL_W-1:0]   trap_lvl,
  input  logic [TYPE_W-1:0] trap_type,
  output logic              irq_req,
  output logic [TYPE_W-1:0] irq_type,
  output logic              wake
);

  logic [LEVELS-1:0] soft_lvl, fold, pend, ext_q;
  logic              tmr_hit, found, blocked;
  logic [PIL_W-1:0]  win;
  logic [TYPE_W-1:0] new_type;

  assign tmr_hit  = soft_reg[0] | soft_reg[SOFT_W-1];
  assign soft_lvl = soft_reg[LEVELS-1:0] & ~LEVELS'(1);
  assign fold     = LEVELS'(tmr_hit) << FOLD_LVL;
  assign pend     = ext_irq | soft_lvl | fold;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = LEVELS - 1; i >= 1; i--) begin
      if (!found && pend[i] && (PIL_W'(i) > cur_pil)) begin
        found = 1'b1;
        win   = PIL_W'(i);
      end
    end
  end

  assign new_type = TYPE_W'(TRAP_BASE) | TYPE_W'(win);
  assign blocked  = (trap_lvl != '0) && (trap_type > new_type);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req  <= 1'b0;
      irq_type <= '0;
      ext_q    <= '0;
      wake     <= 1'b0;
    end else begin
      ext_q <= ext_irq;
      wake  <= |(ext_irq & ~ext_q);
      if (pend == '0) begin
        irq_req  <= 1'b0;
        irq_type <= '0;
      end else if (irq_en && found && !blocked && (new_type != irq_type)) begin
        irq_req  <= 1'b1;
        irq_type <= new_type;
      end
    end
  end

endmodule

// File: rtl/pil_arbiter_chk.sv
module pil_arbiter_chk #(
  parameter int LEVELS    = 16,
  parameter int TRAP_BASE = 'h40,
  parameter int TYPE_W    = 9,
  parameter int TL_W      = 3,
  localparam int PIL_W    = $clog2(LEVELS),
  localparam int SOFT_W   = LEVELS + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LEVELS-1:0] ext_irq,
  input logic [SOFT_W-1:0] soft_reg,
  input logic [PIL_W-1:0]  cur_pil,
  input logic              irq_en,
  input logic [TL_W-1:0]   trap_lvl,
  input logic [TYPE_W-1:0] trap_type,
  input logic              irq_req,
  input logic [TYPE_W-1:0] irq_type,
  input logic              wake
);
  localparam logic [TYPE_W-1:0] T_LO = TYPE_W'(TRAP_BASE);
  localparam logic [TYPE_W-1:0] T_HI = TYPE_W'(TRAP_BASE + LEVELS);

  logic [LEVELS-1:0] prev;
  logic              any_in;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= ext_irq;
  assign any_in = (ext_irq != '0) || (soft_reg != '0);

  a_r4_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !any_in |=> (!irq_req && irq_type == '0));

  a_r6_type_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_type > T_LO && irq_type < T_HI));

  a_r6_type_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_type == '0);

  a_r5_above_pil: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> irq_type[PIL_W-1:0] > $past(cur_pil));

  a_r8_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && any_in) |=> ($stable(irq_req) && $stable(irq_type)));

  a_r7_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (any_in && trap_lvl != '0 && trap_type >= T_HI) |=> ($stable(irq_req) && $stable(irq_type)));

  a_r10_wake_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ext_irq & ~prev)) |=> wake);

  a_r10_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(ext_irq & ~prev)) |=> !wake);
endmodule

bind pil_arbiter pil_arbiter_chk #(
  .LEVELS(LEVELS), .TRAP_BASE(TRAP_BASE), .TYPE_W(TYPE_W), .TL_W(TL_W)
) u_chk (.*);

// File: tb/pil_arbiter_bench.sv
`timescale 1ns/1ps
module pil_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_irq = '0;
  logic [16:0] soft_reg = '0;
  logic [3:0]  cur_pil = '0;
  logic        irq_en = 1'b0;
  logic [2:0]  trap_lvl = '0;
  logic [8:0]  trap_type = '0;
  logic        irq_req, wake;
  logic [8:0]  irq_type;

  int checks = 0, errors = 0;
  bit done = 0, cmp_on = 0;

  always #2.5 clk = ~clk;

  pil_arbiter u_pil_arbiter (.*);

  // behavioural reference
  bit m_req, m_wake;
  int m_type;
  logic [15:0] m_prev;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_type = 0; m_wake = 0; m_prev = '0;
    end else begin
      int mask, lvl;
      mask = ext_irq;
      for (int b = 1; b < 16; b++) if (soft_reg[b]) mask |= (1 << b);
      if (soft_reg[0] || soft_reg[16]) mask |= (1 << 14);
      m_wake = (ext_irq & ~m_prev) != 0;
      m_prev = ext_irq;
      if (mask == 0) begin
        m_req = 0; m_type = 0;
      end else if (irq_en) begin
        lvl = -1;
        for (int l = 15; l > cur_pil; l--) if (lvl < 0 && mask[l]) lvl = l;
        if (lvl > 0) begin
          int nt;
          nt = 'h40 + lvl;
          if (!(trap_lvl != 0 && trap_type > nt) && nt != m_type) begin
            m_req = 1; m_type = nt;
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_on && !done) begin
    chk("R5/R7 model req", irq_req, m_req);
    chk("R6 model type", irq_type, m_type);
    chk("R10 model wake", wake, m_wake);
  end

  task automatic put(logic [15:0] e, logic [16:0] s, logic [3:0] p, logic en,
                     logic [2:0] tl, logic [8:0] tt);
    ext_irq = e; soft_reg = s; cur_pil = p; irq_en = en; trap_lvl = tl; trap_type = tt;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset req", irq_req, 0);
    chk("R11 reset type", irq_type, 0);
    chk("R11 reset wake", wake, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1;

    put(16'h0020, 0, 0, 1, 0, 0);
    chk("R1 level5 req", irq_req, 1);
    chk("R1 level5 type", irq_type, 'h45);
    chk("R10 wake on rise", wake, 1);
    put(16'h0220, 0, 0, 1, 0, 0);
    chk("R5 highest wins", irq_type, 'h49);
    put(16'h0220, 0, 0, 1, 0, 0);
    chk("R10 wake one cycle", wake, 0);
    put(16'h0220, 0, 9, 1, 0, 0);
    chk("R9 none above pil holds", irq_type, 'h49);
    put(16'h1220, 0, 9, 1, 0, 0);
    chk("R5 strictly above pil", irq_type, 'h4C);
    put(0, 0, 0, 1, 0, 0);
    chk("R4 idle req", irq_req, 0);
    chk("R4 idle type", irq_type, 0);
    put(0, 17'h10000, 0, 1, 0, 0);
    chk("R3 system tick folds to 14", irq_type, 'h4E);
    put(0, 0, 0, 1, 0, 0);
    put(0, 17'h00001, 0, 1, 0, 0);
    chk("R3 tick folds to 14", irq_type, 'h4E);
    put(0, 17'h00008, 0, 1, 0, 0);
    chk("R2 soft level3", irq_type, 'h43);
    put(16'h8000, 17'h00008, 0, 0, 0, 0);
    chk("R8 disabled holds", irq_type, 'h43);
    put(16'h8000, 17'h00008, 0, 1, 1, 9'h050);
    chk("R7 higher trap blocks", irq_type, 'h43);
    put(16'h8000, 17'h00008, 0, 1, 1, 9'h04F);
    chk("R7 equal trap allows", irq_type, 'h4F);
    put(16'h0010, 0, 0, 1, 2, 9'h04A);
    chk("R7 blocks level4", irq_type, 'h4F);
    put(16'h0010, 0, 0, 1, 0, 9'h1FF);
    chk("R7 trap level zero allows", irq_type, 'h44);
    put(0, 0, 0, 1, 0, 0);
    put(16'h0001, 0, 0, 1, 0, 0);
    chk("R9 level0 never selected", irq_req, 0);
    chk("R10 wake level0 rise", wake, 1);
    put(0, 17'h00001, 0, 1, 0, 0);
    put(0, 17'h00001, 15, 1, 0, 0);
    chk("R2 bit0 not level0", irq_type, 'h4E);

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] e;
      logic [16:0] s;
      e = 16'($urandom) & 16'($urandom) & 16'($urandom);
      s = 17'($urandom) & 17'($urandom) & 17'($urandom);
      if ($urandom % 4 == 0) e = '0;
      if ($urandom % 3 == 0) s = '0;
      put(e, s, 4'($urandom), ($urandom % 4) != 0,
          ($urandom % 2) ? 3'($urandom) : 3'd0, 9'('h38 + $urandom % 32));
    end
    finish_run();
  end
endmodule